// File: doc/BRIEF.md
# Device Error Signaling Sequencer

This block sits beside the error detectors of a PCI Express function. It takes at most one detected error per cycle, given as a status vector with one bit set, a correctable flag, an advisory-candidate flag and a requester source ID. It updates the device status flags and the correctable and uncorrectable status vectors. It applies the mask, severity and enable settings to decide whether an error message goes upstream and at which severity.

For uncorrectable errors that are not masked, the block asks an external header-log store to record the error. If that store answers that it overflowed, the sequencer spends one extra cycle. In that cycle it injects a correctable header-log-overflow error through the same decision path, so a second message follows the first. Settings and status clears arrive on a single write port. Routing of messages and the log storage itself belong to other blocks.

Top module: `err_seq`

## Requirements
- R1: Only bits in the supported set count: uncorrectable bits 4, 5 and 12..25; correctable bits 0, 6, 7, 8 and 12..15. If the filtered vector has zero bits or more than one bit, `reject_o` pulses one cycle after the offer. In that case nothing changes: no status, no log request, no message.
- R2: A correctable error sets device status bit 0 (correctable detected) and sets its own bit in `cor_sta_o`.
- R3: A correctable error whose bit is set in the correctable mask (select 0) sends no message, but its status is still recorded.
- R4: A correctable message needs control bit 0 (correctable reporting). If the error is an unsupported request (uncorrectable bit 20) taking the advisory path, it also needs control bit 3 (UR reporting). Such an error also sets device status bit 3.
- R5: The severity of an uncorrectable error comes from the severity register (select 2); a set bit means fatal. After reset that register holds bits 4, 5, 13, 17, 18 and 22. A fatal error sets device status bit 2 and a non-fatal one sets bit 1. An unsupported request also sets bit 3.
- R6: An uncorrectable error masked in the uncorrectable mask (select 1) sets its bit in `unc_sta_o`. It is neither logged nor reported.
- R7: An unmasked uncorrectable error raises `log_req_o` in the cycle it is offered, with `log_stat_o` holding its single bit, and sets its bit in `unc_sta_o`.
- R8: An unmasked uncorrectable error sends a message of severity 2 (fatal) or 1 (non-fatal) when control bit 4 (system-error enable) is set, or when the reporting enable for its severity is set: bit 2 for fatal, bit 1 for non-fatal. An unsupported request is dropped when both control bits 3 and 4 are clear.
- R9: A non-fatal uncorrectable error flagged advisory is handled as correctable error bit 13. That bit is set in `cor_sta_o` and device status bit 0 is set. Its uncorrectable status bit is always set. It is logged only if its uncorrectable mask bit is clear. Its message has severity 0. A fatal error flagged advisory is handled as a normal uncorrectable error.
- R10: If `log_ovf_i` is high during a log request, `busy_o` is high for the next cycle and `err_ready_o` is low. During that cycle offered errors are ignored, and a correctable error bit 15 runs through the same decision path. Its message, if enabled, appears one cycle after the original message and carries the original source ID.
- R11: After reset, control, both status vectors and the device status are zero, and the correctable mask holds bit 13. Selects 4, 5 and 6 clear the device, correctable and uncorrectable status bits written as one. A bit written as zero stays unchanged.
- R12: `msg_valid_o` pulses one cycle after the accepted error, together with `msg_sev_o` (0 correctable, 1 non-fatal, 2 fatal) and `msg_src_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| err_valid_i | input | 1 | Error offered this cycle |
| err_status_i | input | 32 | Error bit, one-hot expected |
| err_corr_i | input | 1 | Error is correctable |
| err_adv_i | input | 1 | Error may be treated as advisory non-fatal |
| err_src_i | input | SRC_W | Source ID of the error |
| err_ready_o | output | 1 | Offers are taken this cycle |
| busy_o | output | 1 | Overflow follow-up in progress |
| reject_o | output | 1 | Last offer had an invalid status vector |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Register write data |
| dev_sta_o | output | 4 | Device status flags |
| cor_sta_o | output | 32 | Correctable status vector |
| unc_sta_o | output | 32 | Uncorrectable status vector |
| log_req_o | output | 1 | Header-log record request |
| log_stat_o | output | 32 | Error bit being logged |
| log_ovf_i | input | 1 | Log store overflowed on this request |
| msg_valid_o | output | 1 | Error message emitted |
| msg_sev_o | output | 2 | Message severity |
| msg_src_o | output | SRC_W | Message source ID |

## Verification
The bench builds the block with its defaults: a programmable severity register and 16-bit source IDs. With these settings the reset-time default fatal set is exercised, and rewriting the severity register then flips both directions of the fatal/non-fatal split. Each table entry carries its own source ID, so a message that carries a stale or swapped ID shows up in the checks. The overflow case holds a second error on the inputs during the busy cycle, to show that it is ignored and that the follow-up message keeps the original ID.

// File: rtl/err_seq_pkg.sv
`timescale 1ns/1ps
package err_seq_pkg;
  localparam int STAT_W = 32;
  localparam int CTL_W  = 5;
  localparam int DEV_W  = 4;

  localparam logic [STAT_W-1:0] UNC_SUP      = 32'h03FF_F030;
  localparam logic [STAT_W-1:0] COR_SUP      = 32'h0000_F1C1;
  localparam logic [STAT_W-1:0] DEF_FATAL    = 32'h0046_2030;
  localparam logic [STAT_W-1:0] COR_MASK_RST = 32'h0000_2000;

  localparam int UR_BIT  = 20;
  localparam int ADV_BIT = 13;
  localparam int HLO_BIT = 15;

  localparam int DS_CED  = 0;
  localparam int DS_NFED = 1;
  localparam int DS_FED  = 2;
  localparam int DS_URD  = 3;

  localparam int CT_COR  = 0;
  localparam int CT_NF   = 1;
  localparam int CT_FAT  = 2;
  localparam int CT_UR   = 3;
  localparam int CT_SERR = 4;

  localparam logic [2:0] SEL_CMASK = 3'd0;
  localparam logic [2:0] SEL_UMASK = 3'd1;
  localparam logic [2:0] SEL_SEVER = 3'd2;
  localparam logic [2:0] SEL_CTL   = 3'd3;
  localparam logic [2:0] SEL_DSTA  = 3'd4;
  localparam logic [2:0] SEL_CSTA  = 3'd5;
  localparam logic [2:0] SEL_USTA  = 3'd6;

  localparam logic [1:0] SEV_COR = 2'd0;
  localparam logic [1:0] SEV_NF  = 2'd1;
  localparam logic [1:0] SEV_FAT = 2'd2;

  typedef struct packed {
    logic              ok;
    logic [DEV_W-1:0]  dev_set;
    logic [STAT_W-1:0] cor_set;
    logic [STAT_W-1:0] unc_set;
    logic              log_req;
    logic              msg_vld;
    logic [1:0]        msg_sev;
  } verdict_t;
endpackage

// File: rtl/err_seq_decide.sv
`timescale 1ns/1ps
module err_seq_decide
  import err_seq_pkg::*;
#(
  parameter bit HAS_SEVER = 1'b1
) (
  input  logic [STAT_W-1:0] stat_i,
  input  logic              corr_i,
  input  logic              adv_i,
  input  logic [STAT_W-1:0] cor_mask_i,
  input  logic [STAT_W-1:0] unc_mask_i,
  input  logic [STAT_W-1:0] sever_i,
  input  logic [CTL_W-1:0]  ctl_i,
  output verdict_t          v_o
);
  localparam logic [STAT_W-1:0] ADV_ONE = STAT_W'(1) << ADV_BIT;

  logic [STAT_W-1:0] sup, cbit;
  logic ok, fatal, ur, umasked;

  assign sup     = stat_i & (corr_i ? COR_SUP : UNC_SUP);
  assign ok      = (sup != '0) && ((sup & (sup - STAT_W'(1))) == '0);
  assign ur      = !corr_i && sup[UR_BIT];
  assign umasked = |(unc_mask_i & sup);
  assign cbit    = corr_i ? sup : ADV_ONE;

  generate
    if (HAS_SEVER) begin : g_sever_reg
      assign fatal = |(sup & sever_i);
    end else begin : g_sever_fixed
      assign fatal = |(sup & DEF_FATAL);
    end
  endgenerate

  always_comb begin
    v_o    = '0;
    v_o.ok = ok;
    if (ok) begin
      if (corr_i || (adv_i && !fatal)) begin
        // correctable or advisory non-fatal path
        v_o.dev_set[DS_CED] = 1'b1;
        v_o.dev_set[DS_URD] = ur;
        v_o.cor_set         = cbit;
        if (!corr_i) begin
          v_o.unc_set = sup;
          v_o.log_req = !umasked;
        end
        v_o.msg_vld = !(|(cor_mask_i & cbit)) && ctl_i[CT_COR] && (!ur || ctl_i[CT_UR]);
        v_o.msg_sev = SEV_COR;
      end else begin
        v_o.dev_set[DS_FED]  = fatal;
        v_o.dev_set[DS_NFED] = !fatal;
        v_o.dev_set[DS_URD]  = ur;
        v_o.unc_set          = sup;
        v_o.msg_sev          = fatal ? SEV_FAT : SEV_NF;
        if (!umasked) begin
          v_o.log_req = 1'b1;
          v_o.msg_vld = !(ur && !ctl_i[CT_UR] && !ctl_i[CT_SERR]) &&
                        (ctl_i[CT_SERR] || (fatal ? ctl_i[CT_FAT] : ctl_i[CT_NF]));
        end
      end
    end
  end
endmodule

// File: rtl/err_seq_regs.sv
`timescale 1ns/1ps
module err_seq_regs
  import err_seq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [2:0]        sel_i,
  input  logic [STAT_W-1:0] wdata_i,
  input  logic              upd_i,
  input  logic [DEV_W-1:0]  dev_set_i,
  input  logic [STAT_W-1:0] cor_set_i,
  input  logic [STAT_W-1:0] unc_set_i,
  output logic [STAT_W-1:0] cor_mask_o,
  output logic [STAT_W-1:0] unc_mask_o,
  output logic [STAT_W-1:0] sever_o,
  output logic [CTL_W-1:0]  ctl_o,
  output logic [DEV_W-1:0]  dev_sta_o,
  output logic [STAT_W-1:0] cor_sta_o,
  output logic [STAT_W-1:0] unc_sta_o
);
  logic [DEV_W-1:0]  dev_clr, dev_set;
  logic [STAT_W-1:0] cor_clr, unc_clr, cor_set, unc_set;

  assign dev_clr = (we_i && sel_i == SEL_DSTA) ? wdata_i[DEV_W-1:0] : '0;
  assign cor_clr = (we_i && sel_i == SEL_CSTA) ? wdata_i : '0;
  assign unc_clr = (we_i && sel_i == SEL_USTA) ? wdata_i : '0;
  assign dev_set = upd_i ? dev_set_i : '0;
  assign cor_set = upd_i ? cor_set_i : '0;
  assign unc_set = upd_i ? unc_set_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cor_mask_o <= COR_MASK_RST;
      unc_mask_o <= '0;
      sever_o    <= DEF_FATAL;
      ctl_o      <= '0;
    end else if (we_i) begin
      case (sel_i)
        SEL_CMASK: cor_mask_o <= wdata_i & COR_SUP;
        SEL_UMASK: unc_mask_o <= wdata_i & UNC_SUP;
        SEL_SEVER: sever_o    <= wdata_i & UNC_SUP;
        SEL_CTL:   ctl_o      <= wdata_i[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  // new detections win over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dev_sta_o <= '0;
      cor_sta_o <= '0;
      unc_sta_o <= '0;
    end else begin
      dev_sta_o <= (dev_sta_o & ~dev_clr) | dev_set;
      cor_sta_o <= (cor_sta_o & ~cor_clr) | cor_set;
      unc_sta_o <= (unc_sta_o & ~unc_clr) | unc_set;
    end
  end

  assert_unc_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && sel_i == SEL_USTA) |-> ((unc_sta_o & $past(unc_sta_o)) == $past(unc_sta_o)));
  assert_cor_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(we_i && sel_i == SEL_CSTA) |-> ((cor_sta_o & $past(cor_sta_o)) == $past(cor_sta_o)));
endmodule

// File: rtl/err_seq_fsm.sv
`timescale 1ns/1ps
module err_seq_fsm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ovf_hit_i,
  output logic in_ovf_o
);
  typedef enum logic {ST_IDLE, ST_OVF} state_t;
  state_t state_q, state_d;

  always_comb begin
    state_d = ST_IDLE;
    if (state_q == ST_IDLE && ovf_hit_i) state_d = ST_OVF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  assign in_ovf_o = (state_q == ST_OVF);

  assert_ovf_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ovf_o |=> !in_ovf_o);
  assert_ovf_cause_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_ovf_o |-> $past(ovf_hit_i));
endmodule

// File: rtl/err_seq.sv
`timescale 1ns/1ps
module err_seq
  import err_seq_pkg::*;
#(
  parameter int SRC_W     = 16,
  parameter bit HAS_SEVER = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              err_valid_i,
  input  logic [STAT_W-1:0] err_status_i,
  input  logic              err_corr_i,
  input  logic              err_adv_i,
  input  logic [SRC_W-1:0]  err_src_i,
  output logic              err_ready_o,
  output logic              busy_o,
  output logic              reject_o,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [STAT_W-1:0] reg_wdata_i,
  output logic [DEV_W-1:0]  dev_sta_o,
  output logic [STAT_W-1:0] cor_sta_o,
  output logic [STAT_W-1:0] unc_sta_o,
  output logic              log_req_o,
  output logic [STAT_W-1:0] log_stat_o,
  input  logic              log_ovf_i,
  output logic              msg_valid_o,
  output logic [1:0]        msg_sev_o,
  output logic [SRC_W-1:0]  msg_src_o
);
  localparam logic [STAT_W-1:0] HLO_ONE = STAT_W'(1) << HLO_BIT;

  logic              in_ovf, accept, upd, ovf_hit;
  logic [STAT_W-1:0] sel_stat, cor_mask, unc_mask, sever;
  logic [CTL_W-1:0]  ctl;
  logic [SRC_W-1:0]  src_q;
  verdict_t          v;

  assign sel_stat = in_ovf ? HLO_ONE : err_status_i;
  assign accept   = err_valid_i && !in_ovf;
  assign upd      = in_ovf || (accept && v.ok);
  assign log_req_o  = accept && v.log_req;
  assign log_stat_o = log_req_o ? v.unc_set : '0;
  assign ovf_hit    = log_req_o && log_ovf_i;
  assign err_ready_o = !in_ovf;
  assign busy_o      = in_ovf;

  err_seq_decide #(.HAS_SEVER(HAS_SEVER)) i_decide (
    .stat_i     (sel_stat),
    .corr_i     (in_ovf || err_corr_i),
    .adv_i      (!in_ovf && err_adv_i),
    .cor_mask_i (cor_mask),
    .unc_mask_i (unc_mask),
    .sever_i    (sever),
    .ctl_i      (ctl),
    .v_o        (v)
  );

  err_seq_regs i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .upd_i      (upd),
    .dev_set_i  (v.dev_set),
    .cor_set_i  (v.cor_set),
    .unc_set_i  (v.unc_set),
    .cor_mask_o (cor_mask),
    .unc_mask_o (unc_mask),
    .sever_o    (sever),
    .ctl_o      (ctl),
    .dev_sta_o  (dev_sta_o),
    .cor_sta_o  (cor_sta_o),
    .unc_sta_o  (unc_sta_o)
  );

  err_seq_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_hit_i (ovf_hit),
    .in_ovf_o  (in_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q       <= '0;
      msg_valid_o <= 1'b0;
      msg_sev_o   <= SEV_COR;
      msg_src_o   <= '0;
      reject_o    <= 1'b0;
    end else begin
      if (accept) src_q <= err_src_i;
      msg_valid_o <= upd && v.msg_vld;
      msg_sev_o   <= v.msg_sev;
      msg_src_o   <= in_ovf ? src_q : err_src_i;
      reject_o    <= accept && !v.ok;
    end
  end

  assert_msg_follows_accept_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> $past(upd));
  assert_reject_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reject_o |-> (!msg_valid_o && !busy_o));
  assert_log_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    log_req_o |-> ($countones(log_stat_o) == 1));
  assert_busy_blocks_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (!err_ready_o && !log_req_o));
endmodule

// File: tb/test_err_seq.sv
`timescale 1ns/1ps
module test_err_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        err_valid = 1'b0;
  logic [31:0] err_status = '0;
  logic        err_corr = 1'b0;
  logic        err_adv = 1'b0;
  logic [15:0] err_src = '0;
  logic        err_ready, busy, reject;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_sel = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  dev_sta;
  logic [31:0] cor_sta, unc_sta, log_stat;
  logic        log_req;
  logic        log_ovf = 1'b0;
  logic        msg_valid;
  logic [1:0]  msg_sev;
  logic [15:0] msg_src;

  int checks = 0;
  int errors = 0;
  logic        seen_log;
  logic [31:0] seen_log_stat;

  always #2 clk = ~clk;

  err_seq i_err_seq (
    .clk_i(clk), .rst_ni(rst_n),
    .err_valid_i(err_valid), .err_status_i(err_status), .err_corr_i(err_corr),
    .err_adv_i(err_adv), .err_src_i(err_src),
    .err_ready_o(err_ready), .busy_o(busy), .reject_o(reject),
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .dev_sta_o(dev_sta), .cor_sta_o(cor_sta), .unc_sta_o(unc_sta),
    .log_req_o(log_req), .log_stat_o(log_stat), .log_ovf_i(log_ovf),
    .msg_valid_o(msg_valid), .msg_sev_o(msg_sev), .msg_src_o(msg_src)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [31:0] stat;
    logic        corr;
    logic        adv;
    logic [4:0]  ctl;
    logic [31:0] umask;
    logic [31:0] cmask;
    logic [3:0]  e_dev;
    logic [31:0] e_cor;
    logic [31:0] e_unc;
    logic        e_mv;
    logic [1:0]  e_sev;
    logic        e_log;
    logic        e_rej;
  } vec_t;

  localparam int NV = 19;
  // ctl bits: 0 cor, 1 nonfatal, 2 fatal, 3 ur, 4 serr
  localparam vec_t VECS [NV] = '{
    '{4'd2, 32'h1,      1'b1, 1'b0, 5'h01, 32'h0,    32'h0,  4'h1, 32'h1,    32'h0,      1'b1, 2'd0, 1'b0, 1'b0}, // R2
    '{4'd4, 32'h1,      1'b1, 1'b0, 5'h00, 32'h0,    32'h0,  4'h1, 32'h1,    32'h0,      1'b0, 2'd0, 1'b0, 1'b0}, // R4
    '{4'd3, 32'h40,     1'b1, 1'b0, 5'h01, 32'h0,    32'h40, 4'h1, 32'h40,   32'h0,      1'b0, 2'd0, 1'b0, 1'b0}, // R3
    '{4'd5, 32'h10,     1'b0, 1'b0, 5'h04, 32'h0,    32'h0,  4'h4, 32'h0,    32'h10,     1'b1, 2'd2, 1'b1, 1'b0}, // R5
    '{4'd8, 32'h10,     1'b0, 1'b0, 5'h02, 32'h0,    32'h0,  4'h4, 32'h0,    32'h10,     1'b0, 2'd0, 1'b1, 1'b0}, // R8
    '{4'd8, 32'h10,     1'b0, 1'b0, 5'h10, 32'h0,    32'h0,  4'h4, 32'h0,    32'h10,     1'b1, 2'd2, 1'b1, 1'b0}, // R8
    '{4'd7, 32'h1000,   1'b0, 1'b0, 5'h02, 32'h0,    32'h0,  4'h2, 32'h0,    32'h1000,   1'b1, 2'd1, 1'b1, 1'b0}, // R7
    '{4'd6, 32'h1000,   1'b0, 1'b0, 5'h02, 32'h1000, 32'h0,  4'h2, 32'h0,    32'h1000,   1'b0, 2'd0, 1'b0, 1'b0}, // R6
    '{4'd8, 32'h100000, 1'b0, 1'b0, 5'h02, 32'h0,    32'h0,  4'hA, 32'h0,    32'h100000, 1'b0, 2'd0, 1'b1, 1'b0}, // R8
    '{4'd8, 32'h100000, 1'b0, 1'b0, 5'h0A, 32'h0,    32'h0,  4'hA, 32'h0,    32'h100000, 1'b1, 2'd1, 1'b1, 1'b0}, // R8
    '{4'd8, 32'h100000, 1'b0, 1'b0, 5'h12, 32'h0,    32'h0,  4'hA, 32'h0,    32'h100000, 1'b1, 2'd1, 1'b1, 1'b0}, // R8
    '{4'd9, 32'h1000,   1'b0, 1'b1, 5'h01, 32'h0,    32'h0,  4'h1, 32'h2000, 32'h1000,   1'b1, 2'd0, 1'b1, 1'b0}, // R9
    '{4'd9, 32'h1000,   1'b0, 1'b1, 5'h01, 32'h1000, 32'h0,  4'h1, 32'h2000, 32'h1000,   1'b1, 2'd0, 1'b0, 1'b0}, // R9
    '{4'd4, 32'h100000, 1'b0, 1'b1, 5'h01, 32'h0,    32'h0,  4'h9, 32'h2000, 32'h100000, 1'b0, 2'd0, 1'b1, 1'b0}, // R4
    '{4'd9, 32'h10,     1'b0, 1'b1, 5'h04, 32'h0,    32'h0,  4'h4, 32'h0,    32'h10,     1'b1, 2'd2, 1'b1, 1'b0}, // R9
    '{4'd1, 32'h11,     1'b0, 1'b0, 5'h04, 32'h0,    32'h0,  4'h4, 32'h0,    32'h10,     1'b1, 2'd2, 1'b1, 1'b0}, // R1
    '{4'd1, 32'h30,     1'b0, 1'b0, 5'h07, 32'h0,    32'h0,  4'h0, 32'h0,    32'h0,      1'b0, 2'd0, 1'b0, 1'b1}, // R1
    '{4'd1, 32'h2,      1'b0, 1'b0, 5'h07, 32'h0,    32'h0,  4'h0, 32'h0,    32'h0,      1'b0, 2'd0, 1'b0, 1'b1}, // R1
    '{4'd1, 32'h3,      1'b1, 1'b0, 5'h01, 32'h0,    32'h0,  4'h1, 32'h1,    32'h0,      1'b1, 2'd0, 1'b0, 1'b0}  // R1
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [31:0] data);
    @(negedge clk);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic clear_all();
    wr(3'd4, 32'hF);
    wr(3'd5, 32'hFFFF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
  endtask

  // drives one error for one cycle; returns at the negedge after the accepting edge
  task automatic fire(input logic [31:0] st, input logic c, input logic a,
                      input logic [15:0] src, input logic ovf);
    @(negedge clk);
    err_valid = 1'b1; err_status = st; err_corr = c; err_adv = a; err_src = src; log_ovf = ovf;
    #1;
    seen_log = log_req; seen_log_stat = log_stat;
    @(negedge clk);
    err_valid = 1'b0; log_ovf = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 dev_sta", 32'(dev_sta), 32'h0);
    chk("R11 cor_sta", cor_sta, 32'h0);
    chk("R11 unc_sta", unc_sta, 32'h0);
    chk("R11 ready", 32'(err_ready), 32'h1);
    chk("R11 busy", 32'(busy), 32'h0);
    chk("R12 msg idle", 32'(msg_valid), 32'h0);

    // R11 reset correctable mask holds bit 13: advisory message suppressed
    wr(3'd3, 32'h1);
    fire(32'h1000, 1'b0, 1'b1, 16'h0101, 1'b0);
    chk("R11 adv masked by reset mask", 32'(msg_valid), 32'h0);
    chk("R9 adv cor_sta", cor_sta, 32'h2000);
    chk("R9 adv unc_sta", unc_sta, 32'h1000);
    chk("R9 adv logged", 32'(seen_log), 32'h1);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d entry %0d", VECS[i].req, i);
      clear_all();
      wr(3'd1, VECS[i].umask);
      wr(3'd0, VECS[i].cmask);
      wr(3'd3, 32'(VECS[i].ctl));
      fire(VECS[i].stat, VECS[i].corr, VECS[i].adv, 16'hA000 + 16'(i), 1'b0);
      chk({tag, " log_req"}, 32'(seen_log), 32'(VECS[i].e_log));
      if (VECS[i].e_log) chk({tag, " log_stat"}, seen_log_stat, VECS[i].e_unc);
      chk({tag, " reject"}, 32'(reject), 32'(VECS[i].e_rej));
      chk({tag, " msg_valid"}, 32'(msg_valid), 32'(VECS[i].e_mv));
      if (VECS[i].e_mv) begin
        chk({tag, " msg_sev"}, 32'(msg_sev), 32'(VECS[i].e_sev));
        chk({tag, " R12 msg_src"}, 32'(msg_src), 32'(16'hA000 + 16'(i)));
      end
      chk({tag, " dev_sta"}, 32'(dev_sta), 32'(VECS[i].e_dev));
      chk({tag, " cor_sta"}, cor_sta, VECS[i].e_cor);
      chk({tag, " unc_sta"}, unc_sta, VECS[i].e_unc);
    end

    // R10 log overflow follow-up
    clear_all();
    wr(3'd1, 32'h0);
    wr(3'd0, 32'h0);
    wr(3'd3, 32'h3);
    @(negedge clk);
    err_valid = 1'b1; err_status = 32'h1000; err_corr = 1'b0; err_adv = 1'b0;
    err_src = 16'h55AA; log_ovf = 1'b1;
    #1;
    chk("R10 log_req on overflow", 32'(log_req), 32'h1);
    @(negedge clk);
    chk("R10 first msg", 32'(msg_valid), 32'h1);
    chk("R10 first sev", 32'(msg_sev), 32'h1);
    chk("R10 busy", 32'(busy), 32'h1);
    chk("R10 not ready", 32'(err_ready), 32'h0);
    err_status = 32'h1; err_corr = 1'b1; err_src = 16'h1234; log_ovf = 1'b0;
    @(negedge clk);
    err_valid = 1'b0;
    chk("R10 overflow msg", 32'(msg_valid), 32'h1);
    chk("R10 overflow sev", 32'(msg_sev), 32'h0);
    chk("R10 overflow src", 32'(msg_src), 32'h55AA);
    chk("R10 cor_sta only overflow bit", cor_sta, 32'h8000);
    chk("R10 dev_sta", 32'(dev_sta), 32'h3);
    chk("R10 busy cleared", 32'(busy), 32'h0);
    @(negedge clk);
    chk("R10 no third msg", 32'(msg_valid), 32'h0);

    // R5 programmable severity
    clear_all();
    wr(3'd2, 32'h1000);
    wr(3'd3, 32'h4);
    fire(32'h1000, 1'b0, 1'b0, 16'h0202, 1'b0);
    chk("R5 poison now fatal msg", 32'(msg_valid), 32'h1);
    chk("R5 poison now fatal sev", 32'(msg_sev), 32'h2);
    chk("R5 fatal detected", 32'(dev_sta), 32'h4);
    clear_all();
    wr(3'd3, 32'h2);
    fire(32'h10, 1'b0, 1'b0, 16'h0303, 1'b0);
    chk("R5 dlp now nonfatal sev", 32'(msg_sev), 32'h1);
    chk("R5 dlp now nonfatal msg", 32'(msg_valid), 32'h1);
    chk("R5 nonfatal detected", 32'(dev_sta), 32'h2);

    // R11 write-one-to-clear
    wr(3'd6, 32'h0);
    chk("R11 zero write keeps", unc_sta, 32'h10);
    wr(3'd6, 32'h10);
    chk("R11 one write clears", unc_sta, 32'h0);
    wr(3'd4, 32'h1);
    chk("R11 dev partial clear", 32'(dev_sta), 32'h2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule